// File: doc/BRIEF.md
# Banked Register File with Dual Addressing

This block holds a small register store of 32 bytes, organised as four banks of eight registers each. Every byte can be reached in two ways. The short form carries only a 3-bit register index. A separate 2-bit bank-select register picks which bank that index lands in. The absolute form carries a full 5-bit address and reaches any byte, whatever bank is active.

The short-form physical address is the bank select placed above the index: `{bank, idx}`. Register n of bank b is therefore the byte at absolute address 8*b+n. Both ports can read and write. Reads are combinational. Writes commit on the clock edge. When both ports write the same byte in one cycle, the absolute port's data is stored. Software that uses one bank heavily selects it once and then uses short accesses. Occasional access to other banks goes through the absolute port.

Top module: `banked_regfile`

## Requirements
- R1: After reset the bank select reads 0 and all 32 bytes read 0.
- R2: A short-form write of register n while bank b is active stores the data at absolute address 8*b+n, readable on the absolute port from the next cycle.
- R3: An absolute write to address a is readable on the short port from the next cycle, with bank a[4:3] active and index a[2:0].
- R4: Reads are combinational. Whenever the short port's physical address equals the absolute address, both read data outputs are equal.
- R5: A bank-select write takes effect from the next cycle. A short access in the same cycle as the bank-select write still uses the previous bank.
- R6: When both ports write the same physical byte in one cycle, the absolute port's data is stored.
- R7: When both ports write different bytes in one cycle, both writes are stored.
- R8: A short-form write changes no byte outside the active bank.
- R9: A read of a byte in the same cycle that it is written returns the old value.
- R10: While the bank-select write enable is low, the bank select holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_we | input | 1 | Bank-select write enable |
| bank_wdata | input | 2 | New bank-select value |
| bank_sel_o | output | 2 | Current bank select |
| s_idx | input | 3 | Short-form register index |
| s_we | input | 1 | Short-form write enable |
| s_wdata | input | 8 | Short-form write data |
| s_rdata | output | 8 | Short-form read data |
| a_addr | input | 5 | Absolute address |
| a_we | input | 1 | Absolute write enable |
| a_wdata | input | 8 | Absolute write data |
| a_rdata | output | 8 | Absolute read data |

## Verification
The assertions check on every cycle that the bank select follows its write enable (R5, R10). They also check that the two read ports agree whenever they alias (R4), that a colliding write leaves the absolute data in place (R6), and that a lone short write lands at the mapped byte (R2). Other behaviours need whole sequences and are shown only by the bench's sweeps: the reset contents, the isolation of the other banks (R8), simultaneous writes to different bytes (R7), the read-before-write value (R9) and the full aliasing map in both directions (R2, R3).

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DEF_DATA_W        = 8;
  localparam int DEF_NUM_BANKS     = 4;
  localparam int DEF_REGS_PER_BANK = 8;

  // physical byte address of a bank-relative access: bank in the upper bits
  function automatic int phys_addr(input int bank, input int idx, input int idx_w);
    return (bank << idx_w) | idx;
  endfunction

  // which bank an absolute address falls in
  function automatic int bank_of(input int addr, input int idx_w);
    return addr >> idx_w;
  endfunction

  // index within its bank
  function automatic int idx_of(input int addr, input int idx_w);
    return addr & ((1 << idx_w) - 1);
  endfunction
endpackage

// File: rtl/rf_bank_sel.sv
module rf_bank_sel #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bank_q <= '0;
    else if (we) bank_q <= wdata;
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       s_addr,
  input  logic                    s_we,
  input  logic [DATA_W-1:0]       s_wdata,
  input  logic [ADDR_W-1:0]       a_addr,
  input  logic                    a_we,
  input  logic [DATA_W-1:0]       a_wdata,
  output logic [DEPTH*DATA_W-1:0] mem_flat
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic hit_a, hit_s;
    logic [DATA_W-1:0] q;
    assign hit_a = a_we && (a_addr == ADDR_W'(g));
    assign hit_s = s_we && (s_addr == ADDR_W'(g));
    // absolute port has priority on a collision
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (hit_a) q <= a_wdata;
      else if (hit_s) q <= s_wdata;
    end
    assign mem_flat[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH*DATA_W-1:0] mem_flat,
  input  logic [ADDR_W-1:0]       addr,
  output logic [DATA_W-1:0]       rdata
);
  always_comb begin
    rdata = '0;
    for (int k = 0; k < DEPTH; k++)
      if (addr == ADDR_W'(k)) rdata = mem_flat[k*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DATA_W        = rf_pkg::DEF_DATA_W,
  parameter int NUM_BANKS     = rf_pkg::DEF_NUM_BANKS,
  parameter int REGS_PER_BANK = rf_pkg::DEF_REGS_PER_BANK,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int IDX_W  = $clog2(REGS_PER_BANK),
  localparam int ADDR_W = BANK_W + IDX_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic [BANK_W-1:0] bank_sel_o,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic              s_we,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] s_rdata,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata
);
  logic [BANK_W-1:0]       bank_q;
  logic [ADDR_W-1:0]       short_phys;
  logic                    collide;
  logic [DEPTH*DATA_W-1:0] mem_flat;

  rf_bank_sel #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .wdata(bank_wdata), .bank_q(bank_q)
  );

  assign bank_sel_o = bank_q;
  assign short_phys = ADDR_W'(rf_pkg::phys_addr(int'(bank_q), int'(s_idx), IDX_W));
  assign collide    = a_we && s_we && (a_addr == short_phys);

  rf_storage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .s_addr(short_phys), .s_we(s_we), .s_wdata(s_wdata),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata),
    .mem_flat(mem_flat)
  );

  rf_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_s (
    .mem_flat(mem_flat), .addr(short_phys), .rdata(s_rdata)
  );

  rf_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .mem_flat(mem_flat), .addr(a_addr), .rdata(a_rdata)
  );
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_we,
  input logic [BANK_W-1:0] bank_wdata,
  input logic [BANK_W-1:0] bank_sel_o,
  input logic              s_we,
  input logic [DATA_W-1:0] s_wdata,
  input logic [DATA_W-1:0] s_rdata,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_we,
  input logic [DATA_W-1:0] a_wdata,
  input logic [DATA_W-1:0] a_rdata,
  input logic [ADDR_W-1:0] short_phys,
  input logic              collide
);
  a_r5_bank_update: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> bank_sel_o == $past(bank_wdata));

  a_r10_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(bank_sel_o));

  a_r4_alias_read: assert property (@(posedge clk) disable iff (!rst_n)
    (short_phys == a_addr) |-> (s_rdata == a_rdata));

  a_r6_abs_wins: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> (a_addr != $past(a_addr)) || (a_we && a_addr == $past(a_addr))
                || (a_rdata == $past(a_wdata)));

  a_r2_short_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (s_we && !(a_we && a_addr == short_phys)) |=>
      (a_addr != $past(short_phys)) || (a_rdata == $past(s_wdata)));
endmodule

bind banked_regfile rf_checker #(.DATA_W(DATA_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
  .bank_sel_o(bank_sel_o), .s_we(s_we), .s_wdata(s_wdata), .s_rdata(s_rdata),
  .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .short_phys(short_phys), .collide(collide)
);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_we = 1'b0;
  logic [1:0] bank_wdata = '0;
  logic [1:0] bank_sel_o;
  logic [2:0] s_idx = '0;
  logic       s_we = 1'b0;
  logic [7:0] s_wdata = '0;
  logic [7:0] s_rdata;
  logic [4:0] a_addr = '0;
  logic       a_we = 1'b0;
  logic [7:0] a_wdata = '0;
  logic [7:0] a_rdata;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [32];

  always #4 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .bank_sel_o(bank_sel_o), .s_idx(s_idx), .s_we(s_we), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata),
    .a_rdata(a_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_bank(input int b);
    bank_we = 1'b1; bank_wdata = 2'(b);
    tick();
    bank_we = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37 + salt) ^ 8'h5A);
  endfunction

  task automatic sweep_abs(input string req);
    for (int a = 0; a < 32; a++) begin
      a_addr = 5'(a); #1;
      check(req, a_rdata, model[a]);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 32; a++) model[a] = 8'h00;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 bank", bank_sel_o, 0);
    sweep_abs("R1 contents");

    // R2 / R8: short writes per bank, then full absolute sweep
    for (int b = 0; b < 4; b++) begin
      set_bank(b);
      check("R10 bank hold", bank_sel_o, b);
      for (int n = 0; n < 8; n++) begin
        s_idx = 3'(n); s_we = 1'b1; s_wdata = pat(b*8+n, 1);
        tick();
        model[b*8+n] = pat(b*8+n, 1);
      end
      s_we = 1'b0;
      sweep_abs("R2/R8 short write map");
    end

    // R3: absolute writes, read through short form in every bank
    for (int a = 0; a < 32; a++) begin
      a_addr = 5'(a); a_we = 1'b1; a_wdata = pat(a, 99);
      tick();
      model[a] = pat(a, 99);
    end
    a_we = 1'b0;
    for (int b = 0; b < 4; b++) begin
      set_bank(b);
      for (int n = 0; n < 8; n++) begin
        s_idx = 3'(n); a_addr = 5'(b*8+n); #1;
        check("R3 abs->short", s_rdata, model[b*8+n]);
        check("R4 alias equal", s_rdata, a_rdata);
      end
    end

    // R6: collision on byte 0x1B (bank 3 idx 3)
    s_idx = 3'd3; s_we = 1'b1; s_wdata = 8'h11;
    a_addr = 5'd27; a_we = 1'b1; a_wdata = 8'hEE;
    tick();
    s_we = 1'b0; a_we = 1'b0; model[27] = 8'hEE; #1;
    check("R6 abs wins", a_rdata, 8'hEE);

    // R7: different bytes same cycle
    s_idx = 3'd0; s_we = 1'b1; s_wdata = 8'h42;
    a_addr = 5'd5; a_we = 1'b1; a_wdata = 8'h24;
    tick();
    s_we = 1'b0; a_we = 1'b0; model[24] = 8'h42; model[5] = 8'h24;
    sweep_abs("R7 both stored");

    // R9: same-cycle read returns old value
    s_idx = 3'd1; a_addr = 5'd25; s_we = 1'b1; s_wdata = 8'h77; #1;
    check("R9 old value short", s_rdata, model[25]);
    check("R9 old value abs", a_rdata, model[25]);
    tick();
    s_we = 1'b0; model[25] = 8'h77; #1;
    check("R9 new value", a_rdata, 8'h77);

    // R5: bank change and short write in the same cycle (bank 3 -> 1)
    bank_we = 1'b1; bank_wdata = 2'd1;
    s_idx = 3'd6; s_we = 1'b1; s_wdata = 8'hC3;
    tick();
    bank_we = 1'b0; s_we = 1'b0; model[30] = 8'hC3;
    check("R5 bank updated", bank_sel_o, 1);
    sweep_abs("R5 old bank used");
    s_idx = 3'd6; #1;
    check("R5 new bank read", s_rdata, model[14]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule